// File: doc/BRIEF.md
# Fan PWM Output Channel with Selectable Duty Source

This block drives one fan through a pulse-width modulated output. A small register port holds a configuration byte, a software duty byte and a lock flag. A three-bit mode field in the configuration picks where the duty comes from. It can be one of three per-zone automatic duty requests, the largest request within a group of zones, the software duty, a constant full-on level or a constant off level. A polarity bit flips the output. The per-zone requests arrive as 8-bit inputs from a control algorithm outside this block.

The waveform repeats every 256 clocks, driven by a free-running 8-bit counter. The output is active while the counter is below the applied duty, so even a duty of 0xFF leaves one inactive clock in each period. Any change of mode, duty or polarity is captured only in the last clock of a period, so the output never shows a partial pulse. Once software sets the lock flag, the configuration byte is frozen until reset.

Top module: `fan_pwm_channel`

## Requirements
- R1: After reset the configuration reads 0x62 (full-on mode, polarity normal, spin-up field 010), the lock flag reads 0, the software duty register holds 0x00, the duty view reads 0xFF and the output is high.
- R2: Register addresses: 0 is configuration (mode in bits [7:5], polarity in bit 4, bit 3 reserved, spin-up in bits [2:0]), 1 is the duty view / software duty, 2 is the lock flag in bit 0, 3 reads 0. Reads are combinational from rd_addr.
- R3: Modes 000, 001 and 010 apply the request of zone 1, zone 2 and zone 3 respectively.
- R4: Mode 101 applies the larger of the zone 2 and zone 3 requests; mode 110 applies the largest of all three.
- R5: In mode 111 the software duty register is writable and is the applied duty; in every other mode writes to address 1 leave it unchanged.
- R6: Mode 011 holds the output active for all 256 clocks; mode 100 holds it inactive for all 256 clocks.
- R7: In duty-driven modes the output is active while the free-running counter is below the applied duty: duty 0xFF gives 255 active clocks per period, duty 0x00 gives none.
- R8: With the polarity bit set, the output level is inverted in every mode (duty 0xFF gives one high clock per period).
- R9: A new mode, duty source value or polarity is captured when the counter is 255 and takes effect when it returns to 0; the output within a period is unaffected by changes made during it.
- R10: Writing 1 to bit 0 of address 2 sets the lock; writing 0 does not clear it, only reset does; while locked, configuration writes have no effect.
- R11: Outside mode 111 address 1 reads the duty currently applied (0xFF in full-on, 0x00 in disabled); in mode 111 it reads the software duty register.
- R12: The spin-up field and the reserved bit are stored and read back but do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| zone1_duty | input | 8 | Automatic duty request from zone 1 |
| zone2_duty | input | 8 | Automatic duty request from zone 2 |
| zone3_duty | input | 8 | Automatic duty request from zone 3 |
| pwm_out | output | 1 | Fan PWM output |

## Verification
The embedded properties assume that the write strobe, write address and zone requests carry known values on every clock edge after reset. They also assume that the zone requests are the only source of automatic duty, so that a hottest-mode result can be compared with them directly. The bench drives every input from time zero and changes inputs only on falling edges. It changes zone requests and configuration at arbitrary points inside a period, which exercises the boundary capture. Its reference model recomputes the selection and waveform in its own way.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int DUTY_W = 8;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOCK = 2'd2;

  localparam logic [7:0] CFG_RESET = 8'h62;

  typedef enum logic [MODE_W-1:0] {
    MODE_ZONE1  = 3'b000,
    MODE_ZONE2  = 3'b001,
    MODE_ZONE3  = 3'b010,
    MODE_FULL   = 3'b011,
    MODE_OFF    = 3'b100,
    MODE_HOT23  = 3'b101,
    MODE_HOT123 = 3'b110,
    MODE_MANUAL = 3'b111
  } fan_mode_e;

  typedef struct packed {
    logic              force_on;
    logic              force_off;
    logic              inv;
    logic [DUTY_W-1:0] duty;
  } drive_t;

  localparam drive_t DRIVE_RESET = '{force_on: 1'b1, force_off: 1'b0,
                                     inv: 1'b0, duty: {DUTY_W{1'b1}}};

  function automatic logic [DUTY_W-1:0] larger(input logic [DUTY_W-1:0] a,
                                               input logic [DUTY_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic fan_mode_e cfg_mode(input logic [7:0] cfg);
    return fan_mode_e'(cfg[7:5]);
  endfunction

  function automatic logic level_of(input drive_t d, input logic [DUTY_W-1:0] cnt);
    logic act;
    act = d.force_on ? 1'b1 : (d.force_off ? 1'b0 : (cnt < d.duty));
    return act ^ d.inv;
  endfunction
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        cfg,
  output logic [DUTY_W-1:0] sw_duty,
  output logic              locked
);
  logic cfg_wr_blocked;
  logic duty_wr_ignored;
  logic is_manual;

  assign is_manual       = (cfg_mode(cfg) == MODE_MANUAL);
  assign cfg_wr_blocked  = wr_en && (wr_addr == ADDR_CFG) && locked;
  assign duty_wr_ignored = wr_en && (wr_addr == ADDR_DUTY) && !is_manual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RESET;
      sw_duty <= '0;
      locked  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CFG:  if (!locked) cfg <= wr_data;
        ADDR_DUTY: if (is_manual) sw_duty <= wr_data[DUTY_W-1:0];
        ADDR_LOCK: if (wr_data[0]) locked <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_blocked |=> $stable(cfg));
  assert_duty_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    duty_wr_ignored |=> $stable(sw_duty));
endmodule

// File: rtl/fan_pwm_duty_sel.sv
module fan_pwm_duty_sel
  import fan_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg,
  input  logic [DUTY_W-1:0] zone1_duty,
  input  logic [DUTY_W-1:0] zone2_duty,
  input  logic [DUTY_W-1:0] zone3_duty,
  input  logic [DUTY_W-1:0] sw_duty,
  output drive_t            req
);
  fan_mode_e         mode;
  logic [DUTY_W-1:0] hot23;
  logic [DUTY_W-1:0] hot123;
  logic              hot_mode;

  assign mode     = cfg_mode(cfg);
  assign hot23    = larger(zone2_duty, zone3_duty);
  assign hot123   = larger(zone1_duty, hot23);
  assign hot_mode = (mode == MODE_HOT23) || (mode == MODE_HOT123);

  always_comb begin
    req           = '0;
    req.inv       = cfg[4];
    unique case (mode)
      MODE_ZONE1:  req.duty = zone1_duty;
      MODE_ZONE2:  req.duty = zone2_duty;
      MODE_ZONE3:  req.duty = zone3_duty;
      MODE_HOT23:  req.duty = hot23;
      MODE_HOT123: req.duty = hot123;
      MODE_MANUAL: req.duty = sw_duty;
      MODE_FULL: begin
        req.force_on = 1'b1;
        req.duty     = {DUTY_W{1'b1}};
      end
      MODE_OFF: begin
        req.force_off = 1'b1;
        req.duty      = '0;
      end
      default: req.duty = '0;
    endcase
  end

  assert_hot_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_mode |-> (req.duty >= zone2_duty) && (req.duty >= zone3_duty)
                 && ((req.duty == zone2_duty) || (req.duty == zone3_duty)
                     || (req.duty == zone1_duty)));
  assert_hot123_z1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOT123) |-> (req.duty >= zone1_duty));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  drive_t req,
  output drive_t applied,
  output logic   pwm_out
);
  localparam logic [DUTY_W-1:0] CNT_LAST = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt;
  logic              period_end;

  assign period_end = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      applied <= DRIVE_RESET;
    end else begin
      cnt <= cnt + 1'b1;
      if (period_end) applied <= req;
    end
  end

  assign pwm_out = level_of(applied, cnt);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));
  assert_hold_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(applied));
  assert_full_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    applied.force_on |-> (pwm_out != applied.inv));
  assert_off_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    applied.force_off |-> (pwm_out == applied.inv));
endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
  import fan_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [7:0]  zone1_duty,
  input  logic [7:0]  zone2_duty,
  input  logic [7:0]  zone3_duty,
  output logic        pwm_out
);
  logic [7:0]        cfg;
  logic [DUTY_W-1:0] sw_duty;
  logic              locked;
  drive_t            req;
  drive_t            applied;
  logic [DUTY_W-1:0] duty_view;

  fan_pwm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .sw_duty (sw_duty),
    .locked  (locked)
  );

  fan_pwm_duty_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .zone1_duty (zone1_duty),
    .zone2_duty (zone2_duty),
    .zone3_duty (zone3_duty),
    .sw_duty    (sw_duty),
    .req        (req)
  );

  fan_pwm_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .applied (applied),
    .pwm_out (pwm_out)
  );

  assign duty_view = (cfg_mode(cfg) == MODE_MANUAL) ? sw_duty : applied.duty;

  always_comb begin
    case (rd_addr)
      ADDR_CFG:  rd_data = cfg;
      ADDR_DUTY: rd_data = duty_view;
      ADDR_LOCK: rd_data = {7'd0, locked};
      default:   rd_data = 8'd0;
    endcase
  end

  assert_view_manual_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode(cfg) != MODE_MANUAL && rd_addr == ADDR_DUTY) |-> (rd_data == applied.duty));
endmodule

// File: tb/fan_pwm_channel_tb.sv
module fan_pwm_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic [7:0] z1 = 8'd0, z2 = 8'd0, z3 = 8'd0;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fan_pwm_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .zone1_duty(z1), .zone2_duty(z2),
    .zone3_duty(z3), .pwm_out(pwm_out)
  );

  // Reference model state
  int m_cfg, m_man, m_lock, m_cnt;
  int m_duty, m_mode, m_inv;   // applied values; m_mode is the captured mode

  function automatic int pick_duty(int mode, int a, int b, int c, int man);
    int best;
    if (mode == 0) return a;
    if (mode == 1) return b;
    if (mode == 2) return c;
    if (mode == 3) return 255;
    if (mode == 4) return 0;
    if (mode == 7) return man;
    best = c;
    if (b > best) best = b;
    if (mode == 6 && a > best) best = a;
    return best;
  endfunction

  function automatic int model_level();
    int act;
    if (m_mode == 3) act = 1;
    else if (m_mode == 4) act = 0;
    else act = (m_cnt < m_duty) ? 1 : 0;
    return m_inv ? 1 - act : act;
  endfunction

  function automatic int model_read(int a);
    if (a == 0) return m_cfg;
    if (a == 1) return ((m_cfg >> 5) == 7) ? m_man : m_duty;
    if (a == 2) return m_lock;
    return 0;
  endfunction

  function automatic string tag_of_mode(int mode);
    if (mode <= 2) return "R3";
    if (mode == 5 || mode == 6) return "R4";
    if (mode == 7) return "R5";
    return "R6";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 'h62; m_man = 0; m_lock = 0; m_cnt = 0;
      m_mode = 3; m_duty = 255; m_inv = 0;
    end else begin
      if (m_cnt == 255) begin
        m_mode = m_cfg >> 5;
        m_inv  = (m_cfg >> 4) & 1;
        m_duty = pick_duty(m_mode, z1, z2, z3, m_man);
      end
      m_cnt = (m_cnt + 1) % 256;
      if (wr_en) begin
        if (wr_addr == 0 && m_lock == 0) m_cfg = wr_data;
        else if (wr_addr == 1 && (m_cfg >> 5) == 7) m_man = wr_data;
        else if (wr_addr == 2 && wr_data[0]) m_lock = 1;
      end
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(tag_of_mode(m_mode), pwm_out, model_level());
      check(rd_addr == 0 ? "R2" : (rd_addr == 2 ? "R10" : "R11"),
            rd_data, model_read(rd_addr));
    end
  end

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input string req, input int expected);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(req, rd_data, expected);
  endtask

  task automatic sync_period();
    do @(negedge clk); while (m_cnt != 0);
  endtask

  task automatic settle();
    sync_period();
    repeat (3) @(negedge clk);
    sync_period();
  endtask

  task automatic count_active(output int n);
    n = 0;
    sync_period();
    for (int i = 0; i < 256; i++) begin
      #1;
      if (pwm_out) n++;
      @(negedge clk);
    end
  endtask

  task automatic run_mode(input logic [7:0] cfg_val, input int cycles);
    write_reg(2'd0, cfg_val);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    peek(2'd0, "R1", 'h62);
    peek(2'd2, "R1", 0);
    peek(2'd1, "R1", 'hFF);
    check("R1", pwm_out, 1);

    z1 = 8'h40; z2 = 8'h90; z3 = 8'h20;
    // R3: single zone sources
    run_mode(8'h00, 600);
    count_active(n); check("R3", n, 'h40);
    run_mode(8'h20, 533);
    count_active(n); check("R3", n, 'h90);
    run_mode(8'h40, 417);
    count_active(n); check("R3", n, 'h20);
    // R4: hottest groups
    run_mode(8'hA0, 600);
    count_active(n); check("R4", n, 'h90);
    z3 = 8'hB4;
    settle();
    count_active(n); check("R4", n, 'hB4);
    run_mode(8'hC0, 300);
    z1 = 8'hC8;
    settle();
    count_active(n); check("R4", n, 'hC8);
    // R5 / R11: duty write ignored outside manual; view shows applied duty
    write_reg(2'd1, 8'h55);
    peek(2'd1, "R11", 'hC8);
    // R5: manual
    run_mode(8'hE0, 40);
    peek(2'd1, "R5", 0);
    write_reg(2'd1, 8'hFF);
    peek(2'd1, "R5", 'hFF);
    settle();
    count_active(n); check("R7", n, 255);
    write_reg(2'd1, 8'h00);
    settle();
    count_active(n); check("R7", n, 0);
    write_reg(2'd1, 8'h80);
    settle();
    count_active(n); check("R5", n, 128);
    // R9: change mid-period does not disturb the current period
    do @(negedge clk); while (m_cnt != 10);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h80;
    @(negedge clk);
    wr_en = 1'b0;
    #1; check("R9", pwm_out, 1);
    sync_period();
    #1; check("R9", pwm_out, 0);
    // R8: inversion
    run_mode(8'hF0, 300);
    write_reg(2'd1, 8'hFF);
    settle();
    count_active(n); check("R8", n, 1);
    run_mode(8'h80, 300);
    count_active(n); check("R6", n, 0);
    run_mode(8'h90, 300);
    count_active(n); check("R8", n, 256);
    run_mode(8'h70, 300);
    count_active(n); check("R8", n, 0);
    peek(2'd1, "R11", 'hFF);
    // R12: spin-up and reserved bits
    run_mode(8'h6F, 300);
    peek(2'd0, "R12", 'h6F);
    count_active(n); check("R12", n, 256);
    // R10: lock
    write_reg(2'd2, 8'h01);
    peek(2'd2, "R10", 1);
    write_reg(2'd0, 8'h00);
    peek(2'd0, "R10", 'h6F);
    write_reg(2'd2, 8'h00);
    peek(2'd2, "R10", 1);
    settle();
    count_active(n); check("R10", n, 256);
    // R1 again after a second reset, lock released
    do_reset();
    peek(2'd2, "R1", 0);
    peek(2'd0, "R1", 'h62);
    write_reg(2'd0, 8'h00);
    peek(2'd0, "R10", 'h00);
    repeat (600) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule